// File: doc/BRIEF.md
# Asynchronous Expansion-Bus I/O Slave Front End

This block sits between a 32-bit expansion bus and the register file of an I/O slave. It watches an active-low address strobe, a 14-bit word address, an address-enable qualifier and four active-low byte enables. From these it builds the address phase of each access. The read and write strobes arrive already shaped by outside logic. The block turns them into a one-cycle read-select pulse, and into a write-commit pulse that carries data and byte-lane enables to the register file. It drives the bus data lines only while a valid read is under way.

All bus strobes are asynchronous, so they are brought into the core clock through a synchronizer of parameterized depth. The address and byte enables are frozen when the synchronized address strobe rises. The qualifier follows its pin for as long as the strobe is low and is held once the strobe rises. Read and write strobes must stay idle while a DMA burst owns the data path. Any overlap is suppressed and reported on an error output.

Top module: `ioslv_front`

## Requirements
- R1: The register index output takes the value of the address pins that is present when the rising edge of the address strobe is detected. It then holds that value, whatever the address pins do, until the next rising edge.
- R2: The four byte enables are captured at the same rising edge as the address. `lane_en_o` presents them active-high, so bit k is 1 when byte enable k was low. `lane_en_o` holds between captures.
- R3: While the synchronized address strobe is low, `access_valid_o` equals the inverse of `aen_i`, changing in the same cycle as the pin. Once the strobe is high, it keeps the inverse of the last qualifier value seen while the strobe was low.
- R4: A falling read strobe produces exactly one cycle of `rd_sel_o`, provided the access is valid and no DMA burst is active. `reg_idx_o` shows the target index in that cycle.
- R5: A rising write strobe produces exactly one cycle of `wr_commit_o`, provided the access is valid and no DMA burst is active. During that cycle `wr_data_o` holds the bus data last sampled while the strobe was low, and `reg_idx_o` is unchanged from the address phase.
- R6: `wr_lanes_o` bit k (bits 7:0 of the data form lane 0, bits 15:8 form lane 1, and so on) is 1 only during a commit, and then only if byte enable k was latched low. Outside a commit it is 0.
- R7: `bus_oe_o` is 1 exactly while `rd_n_i` is low, the access is valid and no DMA burst is active. While it is 1, `bus_dout_o` equals `rd_data_i`.
- R8: While `dma_busy_i` is high, a low read or write strobe raises `proto_err_o` and blocks select, commit and bus drive. `proto_err_o` returns to 0 once both strobes are idle again.
- R9: Synchronous active-high reset sets the index to 0, the byte enables to none, and the qualifier to invalid. It also clears all pulses and the error flag.
- R10: When the latched qualifier is high, read and write strobes produce no select, no commit and no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_n_i | input | 1 | Address strobe, active low, asynchronous |
| addr_i | input | 14 | Word address from the bus |
| aen_i | input | 1 | Address-enable qualifier, low means this slave is addressed |
| be_n_i | input | 4 | Byte enables, active low |
| rd_n_i | input | 1 | Read strobe, active low, asynchronous |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| dma_busy_i | input | 1 | High while a DMA burst owns the data path |
| bus_din_i | input | 32 | Data from the bus pads |
| bus_dout_o | output | 32 | Data toward the bus pads |
| bus_oe_o | output | 1 | Pad output enable; pads are high impedance when 0 |
| reg_idx_o | output | 14 | Latched register index |
| lane_en_o | output | 4 | Latched byte enables, active high |
| access_valid_o | output | 1 | Decoded access valid (qualifier low) |
| rd_sel_o | output | 1 | One-cycle read-select pulse |
| rd_data_i | input | 32 | Read data from the register file |
| wr_commit_o | output | 1 | One-cycle write-commit pulse |
| wr_data_o | output | 32 | Write data to the register file |
| wr_lanes_o | output | 4 | Per-lane write enables during a commit |
| proto_err_o | output | 1 | Strobe seen during a DMA burst |

## Verification
The sharpest overlap is the commit of one write landing in the same cycle as the address capture of the next access. The bench provokes this by opening a new address phase while the write strobe is still low. It then releases the write strobe and the address strobe on the same clock edge, so their synchronized edges coincide. The scoreboard expects the commit to carry the old index, the old lanes and the old data. It also checks that the new index and lanes appear on the ports right after the commit.

// File: rtl/ioslv_pkg.sv
package ioslv_pkg;

    localparam int ADDR_W  = 14;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int DATA_W  = LANES * LANE_W;

    // Address phase captured at the trailing strobe edge
    typedef struct packed {
        logic [ADDR_W-1:0] idx;
        logic [LANES-1:0]  be_n;
    } addr_phase_t;

    // Raw asynchronous strobes, all active low
    typedef struct packed {
        logic ads_n;
        logic rd_n;
        logic wr_n;
    } strobes_t;

    localparam int STROBE_W = $bits(strobes_t);

    function automatic logic [LANES-1:0] lane_mask(
        input logic [LANES-1:0] be_n,
        input logic             fire
    );
        return fire ? ~be_n : '0;
    endfunction

endpackage

// File: rtl/ioslv_sync.sv
module ioslv_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ioslv_capture.sv
module ioslv_capture
    import ioslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_low,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  be_n_i,
    input  logic              aen_i,
    output addr_phase_t       phase,
    output logic              aen_eff
);

    logic ads_low_q;
    logic ads_rise;
    logic aen_held;

    assign ads_rise = ads_low_q & ~ads_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            ads_low_q  <= 1'b0;
            phase.idx  <= '0;
            phase.be_n <= '1;
            aen_held   <= 1'b1;
        end else begin
            ads_low_q <= ads_low;
            if (ads_rise) begin
                phase.idx  <= addr_i;
                phase.be_n <= be_n_i;
            end
            if (ads_low) aen_held <= aen_i;
        end
    end

    // transparent while the strobe is low, held otherwise
    assign aen_eff = ads_low ? aen_i : aen_held;

endmodule

// File: rtl/ioslv_decode.sv
module ioslv_decode
    import ioslv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_low,
    input  logic              wr_low,
    input  logic              rd_n_raw,
    input  logic              valid,
    input  logic              dma_busy,
    input  logic [LANES-1:0]  be_n,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_sel,
    output logic              wr_commit,
    output logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_lanes,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic              proto_err
);

    logic              rd_low_q;
    logic              wr_low_q;
    logic [DATA_W-1:0] wdata_sh;
    logic              ok;

    assign ok = valid & ~dma_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_low_q  <= 1'b0;
            wr_low_q  <= 1'b0;
            wdata_sh  <= '0;
            proto_err <= 1'b0;
        end else begin
            rd_low_q  <= rd_low;
            wr_low_q  <= wr_low;
            if (wr_low) wdata_sh <= bus_din;
            proto_err <= dma_busy & (rd_low | wr_low);
        end
    end

    assign rd_sel    = rd_low & ~rd_low_q & ok;
    assign wr_commit = ~wr_low & wr_low_q & ok;
    assign wr_data   = wdata_sh;
    assign wr_lanes  = lane_mask(be_n, wr_commit);
    assign bus_oe    = ~rd_n_raw & ok;
    assign bus_dout  = rd_data;

endmodule

// File: rtl/ioslv_front.sv
module ioslv_front
    import ioslv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              aen_i,
    input  logic [LANES-1:0]  be_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic              dma_busy_i,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic [DATA_W-1:0] bus_dout_o,
    output logic              bus_oe_o,
    output logic [ADDR_W-1:0] reg_idx_o,
    output logic [LANES-1:0]  lane_en_o,
    output logic              access_valid_o,
    output logic              rd_sel_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_commit_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [LANES-1:0]  wr_lanes_o,
    output logic              proto_err_o
);

    strobes_t    raw_s;
    strobes_t    sync_s;
    addr_phase_t phase;
    logic        aen_eff;
    logic        ads_high_s;

    assign raw_s = '{ads_n: ads_n_i, rd_n: rd_n_i, wr_n: wr_n_i};

    ioslv_sync #(
        .W       (STROBE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_s),
        .q   (sync_s)
    );

    assign ads_high_s = sync_s.ads_n;

    ioslv_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .ads_low (~sync_s.ads_n),
        .addr_i  (addr_i),
        .be_n_i  (be_n_i),
        .aen_i   (aen_i),
        .phase   (phase),
        .aen_eff (aen_eff)
    );

    assign access_valid_o = ~aen_eff;
    assign reg_idx_o      = phase.idx;
    assign lane_en_o      = ~phase.be_n;

    ioslv_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .rd_low    (~sync_s.rd_n),
        .wr_low    (~sync_s.wr_n),
        .rd_n_raw  (rd_n_i),
        .valid     (access_valid_o),
        .dma_busy  (dma_busy_i),
        .be_n      (phase.be_n),
        .bus_din   (bus_din_i),
        .rd_data   (rd_data_i),
        .rd_sel    (rd_sel_o),
        .wr_commit (wr_commit_o),
        .wr_data   (wr_data_o),
        .wr_lanes  (wr_lanes_o),
        .bus_oe    (bus_oe_o),
        .bus_dout  (bus_dout_o),
        .proto_err (proto_err_o)
    );

endmodule

module ioslv_front_chk
    import ioslv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ads_high,
    input logic              rd_n_i,
    input logic              dma_busy_i,
    input logic              access_valid_o,
    input logic              bus_oe_o,
    input logic              rd_sel_o,
    input logic              wr_commit_o,
    input logic [LANES-1:0]  wr_lanes_o,
    input logic [LANES-1:0]  lane_en_o,
    input logic [ADDR_W-1:0] reg_idx_o
);

    p_idx_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (ads_high && $past(ads_high)) |=> $stable(reg_idx_o));

    p_rdsel_single_r4: assert property (@(posedge clk) disable iff (rst)
        rd_sel_o |=> !rd_sel_o);

    p_commit_single_r5: assert property (@(posedge clk) disable iff (rst)
        wr_commit_o |=> !wr_commit_o);

    p_lanes_subset_r6: assert property (@(posedge clk) disable iff (rst)
        ((wr_lanes_o & ~lane_en_o) == '0) && (wr_lanes_o == '0 || wr_commit_o));

    p_drive_gated_r7: assert property (@(posedge clk) disable iff (rst)
        bus_oe_o |-> (!rd_n_i && access_valid_o));

    p_dma_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        dma_busy_i |-> (!bus_oe_o && !rd_sel_o && !wr_commit_o));

    p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !access_valid_o |-> (!bus_oe_o && !rd_sel_o && !wr_commit_o));

endmodule

bind ioslv_front ioslv_front_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ads_high       (ads_high_s),
    .rd_n_i         (rd_n_i),
    .dma_busy_i     (dma_busy_i),
    .access_valid_o (access_valid_o),
    .bus_oe_o       (bus_oe_o),
    .rd_sel_o       (rd_sel_o),
    .wr_commit_o    (wr_commit_o),
    .wr_lanes_o     (wr_lanes_o),
    .lane_en_o      (lane_en_o),
    .reg_idx_o      (reg_idx_o)
);

// File: tb/ioslv_front_tb_top.sv
module ioslv_front_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ads_n = 1'b1;
    logic [13:0] addr = '0;
    logic        aen = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        dma = 1'b0;
    logic [31:0] bus_din = '0;
    logic [31:0] bus_dout;
    logic        bus_oe;
    logic [13:0] reg_idx;
    logic [3:0]  lane_en;
    logic        access_valid;
    logic        rd_sel;
    logic [31:0] rd_data = '0;
    logic        wr_commit;
    logic [31:0] wr_data;
    logic [3:0]  wr_lanes;
    logic        proto_err;

    always #10 clk = ~clk;

    ioslv_front dut_i (
        .clk            (clk),
        .rst            (rst),
        .ads_n_i        (ads_n),
        .addr_i         (addr),
        .aen_i          (aen),
        .be_n_i         (be_n),
        .rd_n_i         (rd_n),
        .wr_n_i         (wr_n),
        .dma_busy_i     (dma),
        .bus_din_i      (bus_din),
        .bus_dout_o     (bus_dout),
        .bus_oe_o       (bus_oe),
        .reg_idx_o      (reg_idx),
        .lane_en_o      (lane_en),
        .access_valid_o (access_valid),
        .rd_sel_o       (rd_sel),
        .rd_data_i      (rd_data),
        .wr_commit_o    (wr_commit),
        .wr_data_o      (wr_data),
        .wr_lanes_o     (wr_lanes),
        .proto_err_o    (proto_err)
    );

    typedef struct {
        logic [13:0] idx;
        logic [31:0] data;
        logic [3:0]  lanes;
    } wexp_t;

    wexp_t       wq[$];
    logic [13:0] rq[$];
    wexp_t       we;
    logic [13:0] re;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every pulse
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (wr_commit) begin
                if (wq.size() == 0) check(1'b0, "R5", "unexpected commit", 32'd1, 32'd0);
                else begin
                    we = wq.pop_front();
                    check(reg_idx == we.idx, "R5", "commit index", {18'd0, reg_idx}, {18'd0, we.idx});
                    check(wr_data == we.data, "R5", "commit data", wr_data, we.data);
                    check(wr_lanes == we.lanes, "R6", "commit lanes", {28'd0, wr_lanes}, {28'd0, we.lanes});
                end
            end else begin
                check(wr_lanes == 4'h0, "R6", "lanes outside commit", {28'd0, wr_lanes}, 32'd0);
            end
            if (rd_sel) begin
                if (rq.size() == 0) check(1'b0, "R4", "unexpected read select", 32'd1, 32'd0);
                else begin
                    re = rq.pop_front();
                    check(reg_idx == re, "R4", "read index", {18'd0, reg_idx}, {18'd0, re});
                end
            end
        end
    end

    task automatic addr_phase(input logic [13:0] idx, input logic [3:0] ben, input logic q);
        ads_n = 1'b0; addr = idx; be_n = ben; aen = q;
        settle();
        ads_n = 1'b1;
        settle();
        addr = ~idx; be_n = ~ben; aen = ~q;
        settle();
        check(reg_idx == idx, "R1", "held index", {18'd0, reg_idx}, {18'd0, idx});
        check(lane_en == ~ben, "R2", "held lanes", {28'd0, lane_en}, {28'd0, ~ben});
        check(access_valid == !q, "R3", "held qualifier", {31'd0, access_valid}, {31'd0, !q});
    endtask

    task automatic do_write(input logic [13:0] idx, input logic [3:0] ben,
                            input logic [31:0] d, input bit expect_ok);
        bus_din = d;
        wr_n = 1'b0;
        settle();
        if (expect_ok) wq.push_back('{idx: idx, data: d, lanes: ~ben});
        wr_n = 1'b1;
        settle();
        bus_din = ~d;
    endtask

    task automatic do_read(input logic [13:0] idx, input logic [31:0] d, input bit expect_ok);
        rd_data = d;
        if (expect_ok) rq.push_back(idx);
        rd_n = 1'b0;
        settle();
        check(bus_oe == expect_ok, "R7", "drive during read", {31'd0, bus_oe}, {31'd0, expect_ok});
        if (expect_ok) check(bus_dout == d, "R7", "read data", bus_dout, d);
        rd_n = 1'b1;
        @(negedge clk);
        check(bus_oe == 1'b0, "R7", "release after read", {31'd0, bus_oe}, 32'd0);
        settle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(reg_idx == 14'd0, "R9", "reset index", {18'd0, reg_idx}, 32'd0);
        check(lane_en == 4'd0, "R9", "reset lanes", {28'd0, lane_en}, 32'd0);
        check(access_valid == 1'b0, "R9", "reset qualifier", {31'd0, access_valid}, 32'd0);
        check(proto_err == 1'b0 && bus_oe == 1'b0, "R9", "reset error/drive", {30'd0, proto_err, bus_oe}, 32'd0);

        // R1 R2 R5 R6 writes with varied lanes
        addr_phase(14'h0123, 4'b0000, 1'b0);
        do_write(14'h0123, 4'b0000, 32'hDEADBEEF, 1'b1);
        addr_phase(14'h3FFF, 4'b1010, 1'b0);
        do_write(14'h3FFF, 4'b1010, 32'h12345678, 1'b1);
        addr_phase(14'h0000, 4'b1111, 1'b0);
        do_write(14'h0000, 4'b1111, 32'hA5A5A5A5, 1'b1);

        // R4 R7 read
        addr_phase(14'h02A5, 4'b0011, 1'b0);
        do_read(14'h02A5, 32'hCAFEF00D, 1'b1);

        // R10 qualifier high: no commit, no select, no drive
        addr_phase(14'h1111, 4'b0000, 1'b1);
        do_write(14'h1111, 4'b0000, 32'h0BADF00D, 1'b0);
        do_read(14'h1111, 32'h55AA55AA, 1'b0);

        // R3 transparency while the strobe is low
        ads_n = 1'b0; addr = 14'h0042; be_n = 4'b0101; aen = 1'b0;
        settle();
        check(access_valid == 1'b1, "R3", "transparent low", {31'd0, access_valid}, 32'd1);
        aen = 1'b1;
        @(negedge clk);
        check(access_valid == 1'b0, "R3", "transparent high", {31'd0, access_valid}, 32'd0);
        aen = 1'b0;
        @(negedge clk);
        check(access_valid == 1'b1, "R3", "transparent back", {31'd0, access_valid}, 32'd1);
        ads_n = 1'b1;
        settle();
        aen = 1'b1;
        settle();
        check(access_valid == 1'b1, "R3", "held after rise", {31'd0, access_valid}, 32'd1);

        // R8 strobes during DMA
        dma = 1'b1;
        wr_n = 1'b0; bus_din = 32'h77777777;
        settle();
        check(proto_err == 1'b1, "R8", "write in DMA flagged", {31'd0, proto_err}, 32'd1);
        wr_n = 1'b1;
        settle();
        check(proto_err == 1'b0, "R8", "flag clears", {31'd0, proto_err}, 32'd0);
        rd_n = 1'b0;
        settle();
        check(proto_err == 1'b1, "R8", "read in DMA flagged", {31'd0, proto_err}, 32'd1);
        check(bus_oe == 1'b0, "R8", "no drive in DMA", {31'd0, bus_oe}, 32'd0);
        rd_n = 1'b1;
        dma = 1'b0;
        settle();
        check(proto_err == 1'b0, "R8", "flag clears after read", {31'd0, proto_err}, 32'd0);

        // Commit of one access coincides with capture of the next (R5 R1)
        addr_phase(14'h0AAA, 4'b0110, 1'b0);
        bus_din = 32'hFEEDC0DE;
        wr_n = 1'b0;
        settle();
        wq.push_back('{idx: 14'h0AAA, data: 32'hFEEDC0DE, lanes: 4'b1001});
        ads_n = 1'b0; addr = 14'h1555; be_n = 4'b0001; aen = 1'b0;
        settle();
        wr_n = 1'b1; ads_n = 1'b1;
        settle();
        check(reg_idx == 14'h1555, "R1", "next index after overlap", {18'd0, reg_idx}, 32'h1555);
        check(lane_en == 4'b1110, "R2", "next lanes after overlap", {28'd0, lane_en}, 32'hE);

        check(wq.size() == 0, "R5", "pending commits", wq.size(), 32'd0);
        check(rq.size() == 0, "R4", "pending selects", rq.size(), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule